// File: doc/BRIEF.md
# Analog Input Sequencer Register Block

This block is the register front end of an analog-input path. A host on a 16-bit register bus fills a channel list with 8-bit entries. Each entry carries a channel number, a gain code and two input-type flags. The host then starts conversions one at a time by reading the first control register. The block passes the selected entry to an external converter over a request/acknowledge pair. It stores each 12-bit result in a result FIFO, which the host drains through the same address it used to fill the channel list.

The channel list is a scan table, not a consuming queue. Each start takes the entry at the scan pointer and then moves the pointer on. After the last stored entry the pointer returns to the first one. Two enable bits in the second control register keep each store alive; clearing an enable bit empties that store. A status register reports the fill state of both stores and whether a conversion is running. An optional interrupt fires when the result FIFO reaches half full.

Top module: `adcSequencer`

## Requirements
- R1: After reset, control register 1 (offset 0x00) and control register 2 (offset 0x02) read 0x0000, status (offset 0x04) reads 0x0004, convReq and irq are low, and a read of offset 0x10 returns 0.
- R2: While control register 2 bit 9 is 1, a write to offset 0x10 appends data bits 7:0 as a channel-list entry, up to 16 entries. A write to a full list, or a write while bit 9 is 0, is dropped. During a conversion, convEntry presents the stored entry unchanged (channel 3:0, gain 5:4, unipolar 6, differential 7).
- R3: When control register 1 bits 1:0 equal 1 (software trigger), a read of offset 0x00 starts one conversion of the entry at the scan pointer. The pointer then advances and returns to entry 0 after the last stored entry.
- R4: When bits 1:0 equal 0, 2 or 3, reads of offset 0x00 start nothing. Reads of offset 0x00 always return the written value masked to bits 15, 8, 1 and 0.
- R5: A start read is ignored while a conversion is in progress or while the channel list is empty.
- R6: A read of offset 0x10 pops the oldest result, zero-extended from 12 bits. A read of the empty FIFO returns 0 and changes nothing.
- R7: The result FIFO holds 16 results, and a result arriving when it is full is lost. Status bit 4 = full, bit 3 = at least 8 stored, bit 2 = empty, bit 1 = channel list full.
- R8: While control register 2 bit 10 is 0, the result FIFO is held empty and results are discarded. While bit 9 is 0, the channel list is held empty and its scan pointer returns to entry 0. Control register 2 reads back bits 10 and 9 only.
- R9: When the result count rises to 8 while control register 1 bit 8 is set, a flag latches and shows as status bit 8. irq equals this flag ANDed with control register 1 bit 15. Any write to offset 0x04 clears the flag.
- R10: A start raises convReq and sets status bit 0. Both stay high, with convEntry stable, until the cycle in which convAck is sampled high. In that cycle convData is taken as the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access; reads of 0x00 and 0x10 have side effects |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid in the cycle of busRdEn |
| convReq | output | 1 | Conversion request, held until acknowledged |
| convEntry | output | 8 | Channel-list entry of the running conversion |
| convAck | input | 1 | Converter acknowledge, one cycle, carries the result |
| convData | input | 12 | Conversion result, valid with convAck |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs. convAck is a single-cycle pulse that comes only while convReq is high. A bus cycle never raises busRdEn and busWrEn together. The host holds still during a conversion except for further start reads and status reads. The bench's converter model answers only a pending request, after a fixed delay, and the bench drives one bus strobe at a time. In the random phase, every operation except a start waits until any conversion has finished, so the bench's scan-table and FIFO model stays in step with the design.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_SCAN = 2'd2,
    MODE_EXT  = 2'd3
  } convMode_e;

  localparam logic [4:0] OFF_CTRL1 = 5'h00;
  localparam logic [4:0] OFF_CTRL2 = 5'h02;
  localparam logic [4:0] OFF_STAT  = 5'h04;
  localparam logic [4:0] OFF_FIFO  = 5'h10;

  localparam logic [15:0] CTRL1_MASK = 16'h8103;
  localparam logic [15:0] CTRL2_MASK = 16'h0600;

  localparam int C1_IRQ_EN  = 15;
  localparam int C1_HALF_IE = 8;
  localparam int C2_RES_EN  = 10;
  localparam int C2_LIST_EN = 9;

  typedef struct packed {
    logic listPush;
    logic listClear;
    logic startConv;
    logic resPush;
    logic resPop;
    logic resClear;
  } dpStrobe_t;
endpackage

// File: rtl/adcSeqFifo.sv
module adcSeqFifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end
endmodule

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcSeqPkg::*;
#(
  parameter int ENTRY_W    = 8,
  parameter int RES_W      = 12,
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 16,
  localparam int LPW = $clog2(LIST_DEPTH),
  localparam int LCW = $clog2(LIST_DEPTH + 1),
  localparam int RCW = $clog2(RES_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic [ENTRY_W-1:0] listEntry,
  input  logic [RES_W-1:0]   resIn,
  output logic [ENTRY_W-1:0] headEntry,
  output logic               listFull,
  output logic               listEmpty,
  output logic [RES_W-1:0]   resHead,
  output logic               resFull,
  output logic               resHalf,
  output logic               resEmpty
);
  logic [ENTRY_W-1:0] listMem [LIST_DEPTH];
  logic [LCW-1:0]     listCount;
  logic [LPW-1:0]     scanIdx;
  logic [RCW-1:0]     resCount;
  logic               doListPush;

  assign listFull   = (listCount == LCW'(LIST_DEPTH));
  assign listEmpty  = (listCount == '0);
  assign doListPush = strb.listPush && !listFull;
  assign headEntry  = listMem[scanIdx];

  always_ff @(posedge clk) begin
    if (doListPush) listMem[listCount[LPW-1:0]] <= listEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.listClear) begin
      listCount <= '0;
      scanIdx   <= '0;
    end else begin
      if (doListPush) listCount <= listCount + 1'b1;
      if (strb.startConv)
        scanIdx <= ((LCW'(scanIdx) + LCW'(1)) >= listCount) ? '0 : scanIdx + 1'b1;
    end
  end

  adcSeqFifo #(.W(RES_W), .DEPTH(RES_DEPTH)) resFifo (
    .clk   (clk),
    .rstN  (rstN),
    .clear (strb.resClear),
    .push  (strb.resPush),
    .pop   (strb.resPop),
    .din   (resIn),
    .dout  (resHead),
    .count (resCount),
    .full  (resFull),
    .empty (resEmpty)
  );

  assign resHalf = (resCount >= RCW'(RES_DEPTH / 2));
endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int ENTRY_W = 8,
  parameter int RES_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               convAck,
  output logic               convReq,
  output logic [ENTRY_W-1:0] convEntry,
  output logic               irq,
  output dpStrobe_t          strb,
  output logic [ENTRY_W-1:0] listEntry,
  input  logic [ENTRY_W-1:0] headEntry,
  input  logic               listFull,
  input  logic               listEmpty,
  input  logic [RES_W-1:0]   resHead,
  input  logic               resFull,
  input  logic               resHalf,
  input  logic               resEmpty
);
  logic [DATA_W-1:0]  ctrl1Reg, ctrl2Reg;
  logic               busy, irqFlag, halfPrev;
  logic [ENTRY_W-1:0] curEntry;
  logic               hitC1, hitC2, hitSt, hitFifo;
  convMode_e          mode;

  assign hitC1   = (busAddr == ADDR_W'(OFF_CTRL1));
  assign hitC2   = (busAddr == ADDR_W'(OFF_CTRL2));
  assign hitSt   = (busAddr == ADDR_W'(OFF_STAT));
  assign hitFifo = (busAddr == ADDR_W'(OFF_FIFO));
  assign mode    = convMode_e'(ctrl1Reg[1:0]);

  always_comb begin
    strb.listPush  = busWrEn && hitFifo && ctrl2Reg[C2_LIST_EN];
    strb.listClear = !ctrl2Reg[C2_LIST_EN];
    strb.resClear  = !ctrl2Reg[C2_RES_EN];
    strb.resPop    = busRdEn && hitFifo;
    strb.startConv = busRdEn && hitC1 && (mode == MODE_SOFT) && !busy && !listEmpty;
    strb.resPush   = busy && convAck && ctrl2Reg[C2_RES_EN];
  end

  assign listEntry = busWdata[ENTRY_W-1:0];
  assign convReq   = busy;
  assign convEntry = curEntry;
  assign irq       = irqFlag && ctrl1Reg[C1_IRQ_EN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl1Reg <= '0;
      ctrl2Reg <= '0;
    end else if (busWrEn) begin
      if (hitC1) ctrl1Reg <= busWdata & CTRL1_MASK;
      if (hitC2) ctrl2Reg <= busWdata & CTRL2_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      curEntry <= '0;
    end else if (strb.startConv) begin
      busy     <= 1'b1;
      curEntry <= headEntry;
    end else if (busy && convAck) begin
      busy     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlag  <= 1'b0;
      halfPrev <= 1'b0;
    end else begin
      halfPrev <= resHalf;
      if (busWrEn && hitSt)
        irqFlag <= 1'b0;
      else if (ctrl1Reg[C1_HALF_IE] && resHalf && !halfPrev)
        irqFlag <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRdEn) begin
      if (hitC1)   busRdata = ctrl1Reg;
      if (hitC2)   busRdata = ctrl2Reg;
      if (hitSt)   busRdata = DATA_W'({irqFlag, 3'b000, resFull, resHalf, resEmpty, listFull, busy});
      if (hitFifo) busRdata = DATA_W'(resHead);
    end
  end
endmodule

// File: rtl/adcSequencer.sv
module adcSequencer
  import adcSeqPkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int ENTRY_W    = 8,
  parameter int RES_W      = 12,
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               convReq,
  output logic [ENTRY_W-1:0] convEntry,
  input  logic               convAck,
  input  logic [RES_W-1:0]   convData,
  output logic               irq
);
  dpStrobe_t          strb;
  logic [ENTRY_W-1:0] listEntry, headEntry;
  logic [RES_W-1:0]   resHead;
  logic               listFull, listEmpty, resFull, resHalf, resEmpty;

  adcSeqCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRY_W(ENTRY_W), .RES_W(RES_W)) ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWdata(busWdata), .busRdata(busRdata), .convAck(convAck), .convReq(convReq),
    .convEntry(convEntry), .irq(irq), .strb(strb), .listEntry(listEntry),
    .headEntry(headEntry), .listFull(listFull), .listEmpty(listEmpty), .resHead(resHead),
    .resFull(resFull), .resHalf(resHalf), .resEmpty(resEmpty)
  );

  adcSeqData #(.ENTRY_W(ENTRY_W), .RES_W(RES_W), .LIST_DEPTH(LIST_DEPTH), .RES_DEPTH(RES_DEPTH)) data (
    .clk(clk), .rstN(rstN), .strb(strb), .listEntry(listEntry), .resIn(convData),
    .headEntry(headEntry), .listFull(listFull), .listEmpty(listEmpty), .resHead(resHead),
    .resFull(resFull), .resHalf(resHalf), .resEmpty(resEmpty)
  );
endmodule

// File: rtl/adcSequencerChk.sv
module adcSequencerChk
  import adcSeqPkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int ENTRY_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic               busRdEn,
  input logic [DATA_W-1:0]  busRdata,
  input logic               convReq,
  input logic               convAck,
  input logic [ENTRY_W-1:0] convEntry,
  input logic               irq,
  input logic               listEmpty,
  input logic               resFull,
  input logic               resEmpty
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convAck |=> convReq);
  // R10
  entry_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convAck |=> $stable(convEntry));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    resFull |-> !resEmpty);
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busAddr == ADDR_W'(OFF_FIFO) && resEmpty |-> busRdata == '0);
  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == ADDR_W'(OFF_STAT) |=> !irq);
  // R5
  no_start_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReq) |-> $past(!listEmpty));
  // R3
  start_by_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReq) |-> $past(busRdEn && busAddr == ADDR_W'(OFF_CTRL1)));
endmodule

bind adcSequencer adcSequencerChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRY_W(ENTRY_W)) chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busRdata(busRdata), .convReq(convReq), .convAck(convAck), .convEntry(convEntry),
  .irq(irq), .listEmpty(listEmpty), .resFull(resFull), .resEmpty(resEmpty)
);

// File: tb/adcSequencer_test.sv
`timescale 1ns/1ps
module adcSequencer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        convReq;
  logic [7:0]  convEntry;
  logic        convAck = 1'b0;
  logic [11:0] convData = '0;
  logic        irq;

  int errs = 0, total = 0, ackCnt = 0;
  localparam int ACK_DELAY = 4;

  logic [15:0] mCtrl1 = 0, mCtrl2 = 0;
  logic [7:0]  mList [16];
  int          mListCnt = 0, mScan = 0;
  logic [11:0] expQ [$];
  logic [11:0] pending;
  logic        mBusy = 0;

  always #2.5 clk = ~clk;

  adcSequencer uut (.*);

  function automatic logic [11:0] convFn(logic [7:0] e);
    return {e, ~e[3:0]};
  endfunction

  always @(posedge clk) begin
    convAck <= 1'b0;
    if (convReq && !convAck) begin
      if (ackCnt == ACK_DELAY) begin
        convAck  <= 1'b1;
        convData <= convFn(convEntry);
        ackCnt   <= 0;
      end else ackCnt <= ackCnt + 1;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [4:0] a, logic [15:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [4:0] a, output logic [15:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1'b1;
    #1 d = busRdata;
    @(negedge clk); busRdEn = 1'b0;
  endtask

  task automatic wrCtrl1(logic [15:0] v);
    busWrite(5'h00, v); mCtrl1 = v & 16'h8103;
  endtask

  task automatic wrCtrl2(logic [15:0] v);
    busWrite(5'h02, v); mCtrl2 = v & 16'h0600;
    if (!mCtrl2[9]) begin mListCnt = 0; mScan = 0; end
    if (!mCtrl2[10]) expQ.delete();
  endtask

  task automatic pushEntry(logic [7:0] e);
    busWrite(5'h10, {8'hA5, e});
    if (mCtrl2[9] && mListCnt < 16) begin mList[mListCnt] = e; mListCnt++; end
  endtask

  task automatic softStart();
    logic [15:0] d;
    logic go;
    logic [7:0] e;
    go = (mCtrl1[1:0] == 2'd1) && !mBusy && mListCnt > 0;
    e = go ? mList[mScan] : 8'h00;
    busRead(5'h00, d);
    chk("R4 ctrl1 readback", d, mCtrl1);
    if (go) begin
      pending = convFn(e);
      mScan = (mScan + 1 >= mListCnt) ? 0 : mScan + 1;
      mBusy = 1;
      chk("R10 convReq raised", {15'd0, convReq}, 16'd1);
      chk("R2 convEntry", {8'd0, convEntry}, {8'd0, e});
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
    if (mBusy) begin
      if (mCtrl2[10] && expQ.size() < 16) expQ.push_back(pending);
      mBusy = 0;
    end
  endtask

  task automatic popResult(string req);
    logic [15:0] d, e;
    busRead(5'h10, d);
    e = (expQ.size() > 0) ? {4'd0, expQ.pop_front()} : 16'd0;
    chk(req, d, e);
  endtask

  task automatic checkStatus(string req);
    logic [15:0] d, e;
    busRead(5'h04, d);
    e = {11'd0, expQ.size() == 16, expQ.size() >= 8, expQ.size() == 0, mListCnt == 16, mBusy};
    chk(req, d & 16'h001F, e);
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(5'h00, d); chk("R1 ctrl1", d, 16'h0000);
    busRead(5'h02, d); chk("R1 ctrl2", d, 16'h0000);
    busRead(5'h04, d); chk("R1 status", d, 16'h0004);
    busRead(5'h10, d); chk("R1 fifo", d, 16'h0000);
    chk("R1 convReq/irq", {14'd0, convReq, irq}, 16'd0);

    // R8 list disabled: push dropped, start ignored
    wrCtrl1(16'h0001);
    pushEntry(8'h3C);
    softStart(); settle();
    checkStatus("R8 list held empty");
    wrCtrl2(16'hFFFF);
    busRead(5'h02, d); chk("R8 ctrl2 readback", d, 16'h0600);

    // R5 empty list start ignored
    softStart(); settle();
    popResult("R5 empty list no result");

    // R3 wrap over three entries
    pushEntry(8'h12); pushEntry(8'hE7); pushEntry(8'h9A);
    repeat (4) begin softStart(); settle(); end
    repeat (5) popResult("R3 wrap order");

    // R5 + R10 busy: second start ignored, status busy bit
    softStart();
    checkStatus("R10 busy in status");
    softStart();
    settle();
    popResult("R5 one result while busy");
    popResult("R5 second start ignored");

    // R4 other modes
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      wrCtrl1(16'(m));
      softStart(); settle();
      checkStatus("R4 no start in mode");
    end

    // R2 + R7 full list and full result FIFO
    wrCtrl1(16'h0001);
    wrCtrl2(16'h0400); wrCtrl2(16'h0600);
    for (int i = 0; i < 17; i++) pushEntry(8'(i * 13 + 1));
    checkStatus("R2 list full flag");
    for (int i = 0; i < 17; i++) begin softStart(); settle(); end
    checkStatus("R7 result full");
    for (int i = 0; i < 17; i++) popResult("R7 drain order");
    softStart(); settle();
    popResult("R2 dropped entry absent");

    // R8 result clear
    softStart(); settle(); softStart(); settle();
    wrCtrl2(16'h0200);
    checkStatus("R8 result cleared");
    wrCtrl2(16'h0600);
    popResult("R8 cleared fifo pops zero");

    // R9 half-full interrupt
    wrCtrl2(16'h0400); wrCtrl2(16'h0600);
    pushEntry(8'h45);
    wrCtrl1(16'h8101);
    for (int i = 0; i < 7; i++) begin softStart(); settle(); end
    chk("R9 no irq at 7", {15'd0, irq}, 16'd0);
    softStart(); settle();
    chk("R9 irq at 8", {15'd0, irq}, 16'd1);
    wrCtrl1(16'h0101);
    chk("R9 global mask", {15'd0, irq}, 16'd0);
    busRead(5'h04, d); chk("R9 flag in status", d & 16'h0100, 16'h0100);
    wrCtrl1(16'h8101);
    chk("R9 unmask", {15'd0, irq}, 16'd1);
    busWrite(5'h04, 16'h0000);
    chk("R9 status write clears", {15'd0, irq}, 16'd0);
    wrCtrl1(16'h0001);
    wrCtrl2(16'h0200); wrCtrl2(16'h0600);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      if (op != 0 && mBusy) settle();
      case (op)
        0, 1: softStart();
        2, 3: pushEntry(8'($urandom));
        4:    settle();
        5, 6: popResult("R6 random pop");
        7:    checkStatus("R7 random status");
        8:    wrCtrl1(16'($urandom_range(0, 3)) | (($urandom_range(0, 3) != 0) ? 16'h0001 : 16'h0000));
        default: if ($urandom_range(0, 5) == 0) wrCtrl2(16'($urandom) & 16'h0600 | 16'h0200);
      endcase
    end
    settle();
    checkStatus("R7 final status");

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule